// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point numbers (1 sign bit, 8 exponent bits with bias 127, 23 fraction bits) through a five-stage pipeline. One operand pair can be accepted on every enabled clock. The matching 32-bit sum leaves the block after exactly five enabled clock edges, so the output stream runs at one result per cycle. Each result comes with three status flags: overflow, underflow and invalid. The flags describe only that result and do not accumulate.

The first stage sorts each operand into a class: zero, subnormal, normal, infinity or not-a-number. It passes the class down with the raw word. The next stages then work in order: the smaller operand is aligned to the larger one, the two significands are added or subtracted, and the sum is normalised. The last stage rounds to nearest with ties to even, handles the special cases, and registers the word and the flags.

The enable input freezes every stage at once, which lets a stalled consumer hold the pipe. The synchronous reset empties the pipe to all zeros.

Top module: `fp32_pipe_adder`

## Requirements
- R1: For finite operands whose sum is normal and finite, `sum_out` is the correctly rounded sum, with no flag set. Field layout: bit 31 is the sign, bits 30:23 the biased exponent, bits 22:0 the fraction.
- R2: A pair sampled on an enabled edge produces its result on the output after the fifth enabled edge, counting that edge. After the fourth enabled edge the output still shows the previous result.
- R3: Pairs presented on consecutive enabled cycles produce their results on consecutive cycles, in the same order.
- R4: While `en` is low, the output, the flags and every pipeline stage hold their values, and the operand inputs are ignored.
- R5: While `rst` is high at a clock edge, `sum_out` becomes 0x00000000 and all three flags become 0. The operands presented during reset are ignored.
- R6: If either operand is a NaN (exponent 0xFF, fraction nonzero), or the operands are infinities of opposite sign, then the result is 0x7FC00000 and `inv_o` is 1.
- R7: If exactly one operand is an infinity, or both are infinities of the same sign, and no NaN is present, then the result is that infinity (exponent 0xFF, fraction 0) and no flag is set.
- R8: Rounding is to nearest. An exact halfway case rounds to the even fraction (LSB 0). Any discarded part above half rounds up.
- R9: If the rounded exponent reaches 255, the result is an infinity with the sum's sign and `ovf_o` is 1.
- R10: If the exact sum is nonzero but its rounded exponent falls below 1, the result is a zero with the sum's sign and `unf_o` is 1.
- R11: An exact zero sum of operands with opposite signs is +0 (0x00000000). The sum of two -0 operands is -0 (0x80000000). No flag is set in either case.
- R12: Subnormal operands (exponent 0, fraction nonzero) take part with their full value. A sum of subnormals that reaches the normal range is returned exactly.
- R13: At most one flag is set per result, and a flag falls back to 0 on the next result that does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable for every pipeline stage |
| x_in | input | 32 | First operand |
| y_in | input | 32 | Second operand |
| sum_out | output | 32 | Registered sum |
| ovf_o | output | 1 | Overflow flag of the current result |
| unf_o | output | 1 | Underflow flag of the current result |
| inv_o | output | 1 | Invalid-operation flag of the current result |

## Verification
The bench tests addition in several forms: same-sign adds with and without a carry-out, adds of opposite sign where a large cancellation forces a long left shift, and operands whose exponents differ widely, as in the rounding tests. Each form stresses a different part of the path: the carry shift, the leading-zero normaliser, or the sticky bit from alignment. Halfway and just-above-halfway vectors separate ties-to-even from plain round-half-up. Inputs at the range edges (largest finite, smallest normal, subnormal) separate overflow and underflow handling from normal results. A stream of mixed special and ordinary pairs, with enable gaps and a reset in the middle, shows that results stay in order and that the flags are computed per result.

// File: rtl/fp32_pipe_adder.sv
module fp32_pipe_adder (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [31:0] x_in,
  input  logic [31:0] y_in,
  output logic [31:0] sum_out,
  output logic        ovf_o,
  output logic        unf_o,
  output logic        inv_o
);

  localparam logic [2:0] C_ZERO = 3'd0;
  localparam logic [2:0] C_SUB  = 3'd1;
  localparam logic [2:0] C_NORM = 3'd2;
  localparam logic [2:0] C_INF  = 3'd3;
  localparam logic [2:0] C_NAN  = 3'd4;

  function automatic logic [2:0] classify(input logic [31:0] v);
    if (v[30:23] == 8'hFF) return (v[22:0] != 23'd0) ? C_NAN : C_INF;
    if (v[30:23] == 8'h00) return (v[22:0] != 23'd0) ? C_SUB : C_ZERO;
    return C_NORM;
  endfunction

  // stage 1: operand capture and class
  logic [31:0] s1_x, s1_y;
  logic [2:0]  s1_cx, s1_cy;

  // stage 2: ordered and aligned
  logic [26:0] s2_big, s2_sml;
  logic [7:0]  s2_exp;
  logic        s2_sign, s2_sub, s2_nan, s2_inf, s2_infs;

  // stage 3: raw sum
  logic [27:0] s3_sum;
  logic [7:0]  s3_exp;
  logic        s3_sign, s3_sub, s3_nan, s3_inf, s3_infs;

  // stage 4: normalised
  logic [26:0]       s4_n;
  logic signed [9:0] s4_e;
  logic              s4_sign, s4_zero, s4_zs, s4_nan, s4_inf, s4_infs;

  // stage 2 combinational
  logic        x_big;
  logic [31:0] bg, sm;
  logic [2:0]  cbg, csm;
  logic [7:0]  e_bg, e_sm, dexp;
  logic [4:0]  dcap;
  logic [23:0] m_bg, m_sm;
  logic [50:0] wide;
  logic [26:0] aligned;
  logic        nan2, inf2, infs2;

  assign x_big   = s1_x[30:0] >= s1_y[30:0];
  assign bg      = x_big ? s1_x : s1_y;
  assign sm      = x_big ? s1_y : s1_x;
  assign cbg     = x_big ? s1_cx : s1_cy;
  assign csm     = x_big ? s1_cy : s1_cx;
  assign e_bg    = (bg[30:23] == 8'd0) ? 8'd1 : bg[30:23];
  assign e_sm    = (sm[30:23] == 8'd0) ? 8'd1 : sm[30:23];
  assign m_bg    = {cbg == C_NORM, bg[22:0]};
  assign m_sm    = {csm == C_NORM, sm[22:0]};
  assign dexp    = e_bg - e_sm;
  assign dcap    = (dexp > 8'd27) ? 5'd27 : dexp[4:0];
  assign wide    = {m_sm, 27'd0} >> dcap;
  assign aligned = {wide[50:25], wide[24] | (|wide[23:0])};
  assign nan2    = (s1_cx == C_NAN) || (s1_cy == C_NAN) ||
                   (s1_cx == C_INF && s1_cy == C_INF && s1_x[31] != s1_y[31]);
  assign inf2    = (s1_cx == C_INF) || (s1_cy == C_INF);
  assign infs2   = (s1_cx == C_INF) ? s1_x[31] : s1_y[31];

  // stage 3 combinational
  logic [27:0] raw_sum;
  assign raw_sum = s2_sub ? ({1'b0, s2_big} - {1'b0, s2_sml})
                          : ({1'b0, s2_big} + {1'b0, s2_sml});

  // stage 4 combinational
  logic [4:0]        lz;
  logic [26:0]       norm;
  logic signed [9:0] e_norm;

  always_comb begin
    lz = 5'd0;
    for (int i = 0; i < 27; i++)
      if (s3_sum[i]) lz = 5'(26 - i);
  end

  always_comb begin
    if (s3_sum[27]) begin
      norm   = {s3_sum[27:2], s3_sum[1] | s3_sum[0]};
      e_norm = $signed({2'b00, s3_exp}) + 10'sd1;
    end else begin
      norm   = s3_sum[26:0] << lz;
      e_norm = $signed({2'b00, s3_exp}) - $signed({5'd0, lz});
    end
  end

  // stage 5 combinational: round and compose
  logic              inc;
  logic [24:0]       rnd;
  logic [22:0]       frac;
  logic signed [9:0] e_fin;
  logic [31:0]       word;
  logic              f_ovf, f_unf, f_inv;

  assign inc   = s4_n[2] & (s4_n[1] | s4_n[0] | s4_n[3]);
  assign rnd   = {1'b0, s4_n[26:3]} + {24'd0, inc};
  assign frac  = rnd[24] ? rnd[23:1] : rnd[22:0];
  assign e_fin = s4_e + $signed({9'd0, rnd[24]});

  always_comb begin
    word  = {s4_sign, e_fin[7:0], frac};
    f_ovf = 1'b0;
    f_unf = 1'b0;
    f_inv = 1'b0;
    if (s4_nan) begin
      word  = 32'h7FC0_0000;
      f_inv = 1'b1;
    end else if (s4_inf) begin
      word  = {s4_infs, 8'hFF, 23'd0};
    end else if (s4_zero) begin
      word  = {s4_zs, 31'd0};
    end else if (e_fin >= 10'sd255) begin
      word  = {s4_sign, 8'hFF, 23'd0};
      f_ovf = 1'b1;
    end else if (e_fin < 10'sd1) begin
      word  = {s4_sign, 31'd0};
      f_unf = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_x <= '0; s1_y <= '0; s1_cx <= C_ZERO; s1_cy <= C_ZERO;
      s2_big <= '0; s2_sml <= '0; s2_exp <= '0;
      s2_sign <= 1'b0; s2_sub <= 1'b0; s2_nan <= 1'b0; s2_inf <= 1'b0; s2_infs <= 1'b0;
      s3_sum <= '0; s3_exp <= '0;
      s3_sign <= 1'b0; s3_sub <= 1'b0; s3_nan <= 1'b0; s3_inf <= 1'b0; s3_infs <= 1'b0;
      s4_n <= '0; s4_e <= '0;
      s4_sign <= 1'b0; s4_zero <= 1'b1; s4_zs <= 1'b0;
      s4_nan <= 1'b0; s4_inf <= 1'b0; s4_infs <= 1'b0;
      sum_out <= '0; ovf_o <= 1'b0; unf_o <= 1'b0; inv_o <= 1'b0;
    end else if (en) begin
      s1_x  <= x_in;
      s1_y  <= y_in;
      s1_cx <= classify(x_in);
      s1_cy <= classify(y_in);

      s2_big  <= {m_bg, 3'b000};
      s2_sml  <= aligned;
      s2_exp  <= e_bg;
      s2_sign <= bg[31];
      s2_sub  <= s1_x[31] ^ s1_y[31];
      s2_nan  <= nan2;
      s2_inf  <= inf2;
      s2_infs <= infs2;

      s3_sum  <= raw_sum;
      s3_exp  <= s2_exp;
      s3_sign <= s2_sign;
      s3_sub  <= s2_sub;
      s3_nan  <= s2_nan;
      s3_inf  <= s2_inf;
      s3_infs <= s2_infs;

      s4_n    <= norm;
      s4_e    <= e_norm;
      s4_sign <= s3_sign;
      s4_zero <= (s3_sum == 28'd0);
      s4_zs   <= s3_sub ? 1'b0 : s3_sign;
      s4_nan  <= s3_nan;
      s4_inf  <= s3_inf;
      s4_infs <= s3_infs;

      sum_out <= word;
      ovf_o   <= f_ovf;
      unf_o   <= f_unf;
      inv_o   <= f_inv;
    end
  end

endmodule

// File: rtl/fp32_pipe_adder_chk.sv
module fp32_pipe_adder_chk (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic [31:0] x_in,
  input logic [31:0] y_in,
  input logic [31:0] sum_out,
  input logic        ovf_o,
  input logic        unf_o,
  input logic        inv_o
);

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 3'd0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sum_out) && $stable(ovf_o) && $stable(unf_o) && $stable(inv_o));

  a_r6_invalid_word: assert property (@(posedge clk) disable iff (rst)
    inv_o |-> sum_out == 32'h7FC0_0000);

  a_r9_overflow_inf: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> sum_out[30:0] == 31'h7F80_0000);

  a_r10_underflow_zero: assert property (@(posedge clk) disable iff (rst)
    unf_o |-> sum_out[30:0] == 31'd0);

  a_r13_one_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_o, unf_o, inv_o}));

  a_r2_nan_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5 && $past(en, 1) && $past(en, 2) && $past(en, 3) &&
     $past(en, 4) && $past(en, 5) && $past(x_in[30:23], 5) == 8'hFF &&
     $past(x_in[22:0], 5) != 23'd0) |-> inv_o && sum_out == 32'h7FC0_0000);

  logic unused_y;
  assign unused_y = ^y_in;

endmodule

bind fp32_pipe_adder fp32_pipe_adder_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .x_in(x_in), .y_in(y_in),
  .sum_out(sum_out), .ovf_o(ovf_o), .unf_o(unf_o), .inv_o(inv_o)
);

// File: tb/fp32_pipe_adder_bench.sv
module fp32_pipe_adder_bench;

  logic        clk = 1'b0;
  logic        rst, en;
  logic [31:0] x_in, y_in, sum_out;
  logic        ovf_o, unf_o, inv_o;
  int          checks = 0;
  int          errors = 0;

  localparam logic [2:0] F_NONE = 3'b000;
  localparam logic [2:0] F_OVF  = 3'b100;
  localparam logic [2:0] F_UNF  = 3'b010;
  localparam logic [2:0] F_INV  = 3'b001;

  always #2 clk = ~clk;

  fp32_pipe_adder u_fp32_pipe_adder (
    .clk(clk), .rst(rst), .en(en), .x_in(x_in), .y_in(y_in),
    .sum_out(sum_out), .ovf_o(ovf_o), .unf_o(unf_o), .inv_o(inv_o)
  );

  task automatic check(input string tag, input logic [31:0] er, input logic [2:0] ef);
    checks++;
    if (sum_out !== er || {ovf_o, unf_o, inv_o} !== ef) begin
      errors++;
      $display("FAIL %s: got %h flags %b, expected %h flags %b",
               tag, sum_out, {ovf_o, unf_o, inv_o}, er, ef);
    end
  endtask

  task automatic single(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] er, input logic [2:0] ef);
    @(negedge clk);
    x_in = a; y_in = b; en = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(tag, er, ef);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R5 reset state", 32'h0, F_NONE);
  endtask

  task automatic t_basic;
    single("R1 1+1",        32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000, F_NONE);
    single("R1 1.5+2.25",   32'h3FC0_0000, 32'h4010_0000, 32'h4070_0000, F_NONE);
    single("R1 3-1",        32'h4040_0000, 32'hBF80_0000, 32'h4000_0000, F_NONE);
    single("R1 carry 2.0",  32'h3FFF_FFFF, 32'h3400_0000, 32'h4000_0000, F_NONE);
    single("R1 cancel",     32'h3F80_0000, 32'hBF7F_FFFF, 32'h3380_0000, F_NONE);
  endtask

  task automatic t_latency;
    @(negedge clk);
    x_in = 32'h3F80_0000; y_in = 32'h3F80_0000; en = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    x_in = 32'h4040_0000; y_in = 32'h4040_0000;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2 not yet at edge 4", 32'h4000_0000, F_NONE);
    @(posedge clk);
    @(negedge clk);
    check("R2 present at edge 5", 32'h40C0_0000, F_NONE);
  endtask

  task automatic t_stream;
    logic [31:0] va [6] = '{32'h7F7F_FFFF, 32'h3F80_0000, 32'h7F80_0000,
                            32'h3FC0_0000, 32'h0080_0000, 32'h4040_0000};
    logic [31:0] vb [6] = '{32'h7F7F_FFFF, 32'h3F80_0000, 32'hFF80_0000,
                            32'h4010_0000, 32'h8000_0001, 32'hBF80_0000};
    logic [31:0] ve [6] = '{32'h7F80_0000, 32'h4000_0000, 32'h7FC0_0000,
                            32'h4070_0000, 32'h0000_0000, 32'h4000_0000};
    logic [2:0]  vf [6] = '{F_OVF, F_NONE, F_INV, F_NONE, F_UNF, F_NONE};
    for (int c = 0; c < 11; c++) begin
      @(negedge clk);
      if (c >= 5) check($sformatf("R3 R13 stream item %0d", c - 5), ve[c-5], vf[c-5]);
      if (c < 6) begin
        x_in = va[c]; y_in = vb[c]; en = 1'b1;
      end
    end
  endtask

  task automatic t_hold;
    logic [31:0] held;
    logic [2:0]  hf;
    @(negedge clk);
    x_in = 32'h3FC0_0000; y_in = 32'h4010_0000; en = 1'b1;
    @(negedge clk);
    en = 1'b0; x_in = 32'h7FC0_0000; y_in = 32'h7FC0_0000;
    held = sum_out; hf = {ovf_o, unf_o, inv_o};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R4 output held while disabled", held, hf);
    end
    en = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R4 stalled item resumes intact", 32'h4070_0000, F_NONE);
  endtask

  task automatic t_midreset;
    single("R5 pre-reset value", 32'h7F7F_FFFF, 32'h7F7F_FFFF, 32'h7F80_0000, F_OVF);
    @(negedge clk);
    rst = 1'b1; x_in = 32'h7FC0_0000;
    @(posedge clk);
    @(negedge clk);
    check("R5 synchronous reset clears", 32'h0, F_NONE);
    rst = 1'b0; en = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R5 reset-time operands ignored", 32'h0, F_NONE);
  endtask

  task automatic t_invalid;
    single("R6 inf-inf",  32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000, F_INV);
    single("R6 nan+1",    32'h7FC0_0001, 32'h3F80_0000, 32'h7FC0_0000, F_INV);
    single("R6 1+snan",   32'h3F80_0000, 32'hFF80_0001, 32'h7FC0_0000, F_INV);
  endtask

  task automatic t_inf;
    single("R7 inf+1",     32'h7F80_0000, 32'h3F80_0000, 32'h7F80_0000, F_NONE);
    single("R7 5+-inf",    32'h40A0_0000, 32'hFF80_0000, 32'hFF80_0000, F_NONE);
    single("R7 -inf+-inf", 32'hFF80_0000, 32'hFF80_0000, 32'hFF80_0000, F_NONE);
  endtask

  task automatic t_round;
    single("R8 tie to even down", 32'h3F80_0000, 32'h3380_0000, 32'h3F80_0000, F_NONE);
    single("R8 tie to even up",   32'h3F80_0001, 32'h3380_0000, 32'h3F80_0002, F_NONE);
    single("R8 above half",       32'h3F80_0000, 32'h3380_0001, 32'h3F80_0001, F_NONE);
  endtask

  task automatic t_ovf;
    single("R9 +overflow", 32'h7F7F_FFFF, 32'h7F7F_FFFF, 32'h7F80_0000, F_OVF);
    single("R9 -overflow", 32'hFF7F_FFFF, 32'hFF7F_FFFF, 32'hFF80_0000, F_OVF);
  endtask

  task automatic t_unf;
    single("R10 +underflow",  32'h0080_0000, 32'h8000_0001, 32'h0000_0000, F_UNF);
    single("R10 -underflow",  32'h8080_0000, 32'h0000_0001, 32'h8000_0000, F_UNF);
    single("R10 tiny sum",    32'h0000_0001, 32'h0000_0001, 32'h0000_0000, F_UNF);
  endtask

  task automatic t_zero;
    single("R11 1+-1",   32'h3F80_0000, 32'hBF80_0000, 32'h0000_0000, F_NONE);
    single("R11 -0+-0",  32'h8000_0000, 32'h8000_0000, 32'h8000_0000, F_NONE);
    single("R11 +0+-0",  32'h0000_0000, 32'h8000_0000, 32'h0000_0000, F_NONE);
  endtask

  task automatic t_subn;
    single("R12 subnormals to normal", 32'h0040_0000, 32'h0040_0000, 32'h0080_0000, F_NONE);
    single("R12 normal plus subnormal", 32'h0080_0000, 32'h0000_0001, 32'h0080_0001, F_NONE);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b0; x_in = '0; y_in = '0;
    repeat (3) @(posedge clk);
    t_reset();
    rst = 1'b0;
    t_basic();
    t_latency();
    t_stream();
    t_hold();
    t_midreset();
    t_invalid();
    t_inf();
    t_round();
    t_ovf();
    t_unf();
    t_zero();
    t_subn();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule